// File: doc/BRIEF.md
# Phase-Programmable Pixel Data Output Stage

This block sits at the digital edge of an image-sensor front end. It takes converted pixel words as they leave the sampling path and delivers them on a parallel data bus together with a data clock. Each pixel period is divided into a fixed number of fast ticks, 48 by default. The block is given the running tick position and a control word. It places the data transition on a chosen tick, adds a chosen data-to-clock delay, and generates the data clock in one of two modes. In the first mode the clock follows the data phase. In the second it stays locked to the inverted reference clock.

Each word leaves the block a fixed whole number of pixel periods after it was sampled, 11 by default. The delay line is written so that it maps onto shift-register or RAM primitives without a reset. A fill counter forces the output to zero until the line holds real data. The control word is retimed at the pixel-period boundary, so a change never splits a period.

Top module: `pixout_stage`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `dout` and `dclk` are 0. Until the first period boundary, the control word in effect is the reset default: phase 0, tracking clock, delay code 2.
- R2: A word sampled during pixel period k (counted from reset, where period boundaries are the cycles with `tick_pos` = 47) appears on `dout` at the update point of period k+11. At the update points of periods 0 to 10, `dout` is driven to 0.
- R3: `dout` changes only in the cycle after one in which `tick_pos` equals the update position U = (P + D) mod 48, and it holds its value at all other times. P is the effective phase and D is the delay in ticks.
- R4: With control bit 6 = 0 (tracking mode), `dclk` in the cycle after tick t is 1 exactly when (t − P) mod 48 < 24.
- R5: With control bit 6 = 1 (fixed mode), `dclk` in the cycle after tick t is 1 exactly when t ≥ 24, whatever the phase. The data update position still follows R3.
- R6: Control bits [8:7] hold a delay code c in 0..3. The delay is D = c × 5 ticks, which gives 0, 5, 10 or 15 ticks. U wraps past 47 into the start of the period.
- R7: Control bits [5:0] hold the phase code. Codes 0..47 are used as they are, and codes 48..63 are taken as the code minus 48.
- R8: The control word is captured only in the cycle with `tick_pos` = 47. Its value at that cycle governs the whole next period, and values present at other ticks have no effect.
- R9: `samp_data` is taken only when `samp_stb` is high, and the last strobed word in a period is the word for that period. A strobe at tick 47 counts for that period. A period without a strobe repeats the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_pos | input | 6 | Current tick within the pixel period, 0..47 |
| samp_stb | input | 1 | Sample strobe for `samp_data` |
| samp_data | input | 10 | Converted pixel word |
| out_ctrl | input | 9 | Control word: [5:0] phase, [6] fixed clock, [8:7] delay code |
| dout | output | 10 | Registered pixel data output |
| dclk | output | 1 | Registered data clock |

## Verification
The assertions check several behaviours on every cycle. `dout` must hold except just after the update tick, and it must stay zero while the delay line fills. The control word may change only at the period boundary. In fixed mode `dclk` must be high after tick 24, and in tracking mode it must be high just after the phase tick. Other behaviours can only be shown by the bench's scenarios. These are the exact 11-period alignment between strobed words and output words, and the repeat of a word in a period without a strobe. They also include the wrap of phase codes above 47, the wrap of phase plus delay past the period end, and the fact that a mid-period control change is ignored.

// File: rtl/pixout_pkg.sv
package pixout_pkg;
  localparam int PHASE_W = 6;

  typedef struct packed {
    logic [1:0]         dly_code;
    logic               clk_fixed;
    logic [PHASE_W-1:0] phase;
  } out_ctrl_t;

  localparam out_ctrl_t CTRL_RESET = '{dly_code: 2'd2, clk_fixed: 1'b0, phase: '0};
endpackage

// File: rtl/pixout_ctrl_hold.sv
module pixout_ctrl_hold
  import pixout_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      period_end,
  input  out_ctrl_t ctrl_in,
  output out_ctrl_t ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (period_end) begin
      ctrl_q <= ctrl_in;
    end
  end
endmodule

// File: rtl/pixout_phase_gen.sv
module pixout_phase_gen
  import pixout_pkg::*;
#(
  parameter int TICKS    = 48,
  parameter int DLY_STEP = 5
) (
  input  out_ctrl_t          ctrl,
  input  logic [PHASE_W-1:0] tick_pos,
  output logic [PHASE_W-1:0] phase_eff,
  output logic [PHASE_W-1:0] upd_tick,
  output logic               clk_level
);
  localparam int             XW      = PHASE_W + 1;
  localparam logic [XW-1:0]  TICKS_X = XW'(TICKS);
  localparam logic [XW-1:0]  HALF_X  = XW'(TICKS / 2);
  localparam int             NCODES  = 4;

  logic [XW-1:0] dly_lut [NCODES];
  logic [XW-1:0] ph_x, sum_x, tick_x, diff_x;
  logic          track_lvl, fixed_lvl;

  // delay in ticks per code, built from the step parameter
  for (genvar g = 0; g < NCODES; g++) begin : g_dly
    assign dly_lut[g] = XW'(g * DLY_STEP);
  end

  always_comb begin
    ph_x = {1'b0, ctrl.phase};
    if (ph_x >= TICKS_X) ph_x = ph_x - TICKS_X;

    sum_x = ph_x + dly_lut[ctrl.dly_code];
    if (sum_x >= TICKS_X) sum_x = sum_x - TICKS_X;

    tick_x = {1'b0, tick_pos};
    if (tick_x >= ph_x) diff_x = tick_x - ph_x;
    else                diff_x = tick_x + TICKS_X - ph_x;

    track_lvl = (diff_x < HALF_X);
    fixed_lvl = (tick_x >= HALF_X);
    clk_level = ctrl.clk_fixed ? fixed_lvl : track_lvl;
  end

  assign phase_eff = ph_x[PHASE_W-1:0];
  assign upd_tick  = sum_x[PHASE_W-1:0];
endmodule

// File: rtl/pixout_latency_line.sv
module pixout_latency_line #(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              period_end,
  input  logic              samp_stb,
  input  logic [DATA_W-1:0] samp_data,
  output logic [DATA_W-1:0] word_out,
  output logic              filled
);
  localparam int FILL_W = $clog2(LATENCY + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(LATENCY);

  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] entry;
  logic [DATA_W-1:0] stage_q [LATENCY];
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst)           cap_q <= '0;
    else if (samp_stb) cap_q <= samp_data;
  end

  assign entry = samp_stb ? samp_data : cap_q;

  // no reset: shift-register / RAM friendly; gated by the fill counter
  always_ff @(posedge clk) begin
    if (period_end) begin
      stage_q[0] <= entry;
      for (int i = 1; i < LATENCY; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  fill_q <= '0;
    else if (period_end && fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
  end

  assign filled   = (fill_q == FILL_MAX);
  assign word_out = stage_q[LATENCY-1];
endmodule

// File: rtl/pixout_stage.sv
module pixout_stage
  import pixout_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int TICKS    = 48,
  parameter int LATENCY  = 11,
  parameter int DLY_STEP = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tick_pos,
  input  logic               samp_stb,
  input  logic [DATA_W-1:0]  samp_data,
  input  logic [8:0]         out_ctrl,
  output logic [DATA_W-1:0]  dout,
  output logic               dclk
);
  localparam logic [PHASE_W-1:0] LAST_TICK = PHASE_W'(TICKS - 1);

  out_ctrl_t          ctrl_in, ctrl_q;
  logic               period_end;
  logic [PHASE_W-1:0] phase_eff, upd_tick;
  logic               clk_level, filled;
  logic [DATA_W-1:0]  word;

  assign ctrl_in    = out_ctrl_t'(out_ctrl);
  assign period_end = (tick_pos == LAST_TICK);

  pixout_ctrl_hold u_hold (
    .clk(clk), .rst(rst), .period_end(period_end),
    .ctrl_in(ctrl_in), .ctrl_q(ctrl_q)
  );

  pixout_phase_gen #(.TICKS(TICKS), .DLY_STEP(DLY_STEP)) u_phase (
    .ctrl(ctrl_q), .tick_pos(tick_pos), .phase_eff(phase_eff),
    .upd_tick(upd_tick), .clk_level(clk_level)
  );

  pixout_latency_line #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_line (
    .clk(clk), .rst(rst), .period_end(period_end), .samp_stb(samp_stb),
    .samp_data(samp_data), .word_out(word), .filled(filled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      dclk <= 1'b0;
    end else begin
      dclk <= clk_level;
      if (tick_pos == upd_tick) dout <= filled ? word : '0;
    end
  end
endmodule

// File: rtl/pixout_stage_chk.sv
module pixout_stage_chk
  import pixout_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int TICKS   = 48,
  parameter int LATENCY = 11
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] tick_pos,
  input logic [DATA_W-1:0]  dout,
  input logic               dclk,
  input out_ctrl_t          ctrl_q,
  input logic [PHASE_W-1:0] upd_tick,
  input logic [PHASE_W-1:0] phase_eff
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0]      CMAX = CW'(LATENCY);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(TICKS - 1);
  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(TICKS / 2);

  logic [CW-1:0] bnd_cnt;
  always_ff @(posedge clk) begin
    if (rst)                                   bnd_cnt <= '0;
    else if (tick_pos == LAST && bnd_cnt != CMAX) bnd_cnt <= bnd_cnt + 1'b1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> (dout == '0 && !dclk));
  p_fill_zero_r2:  assert property (@(posedge clk) disable iff (rst)
                     (bnd_cnt != CMAX) |=> (dout == '0));
  p_dout_hold_r3:  assert property (@(posedge clk) disable iff (rst)
                     (tick_pos != upd_tick) |=> $stable(dout));
  p_track_rise_r4: assert property (@(posedge clk) disable iff (rst)
                     (!ctrl_q.clk_fixed && tick_pos == phase_eff) |=> dclk);
  p_fixed_hi_r5:   assert property (@(posedge clk) disable iff (rst)
                     (ctrl_q.clk_fixed && tick_pos == HALF) |=> dclk);
  p_fixed_lo_r5:   assert property (@(posedge clk) disable iff (rst)
                     (ctrl_q.clk_fixed && tick_pos == HALF - 1'b1) |=> !dclk);
  p_ctrl_hold_r8:  assert property (@(posedge clk) disable iff (rst)
                     (tick_pos != LAST) |=> $stable(ctrl_q));
endmodule

bind pixout_stage pixout_stage_chk #(.DATA_W(DATA_W), .TICKS(TICKS), .LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst(rst), .tick_pos(tick_pos), .dout(dout), .dclk(dclk),
  .ctrl_q(ctrl_q), .upd_tick(upd_tick), .phase_eff(phase_eff)
);

// File: tb/pixout_stage_tb_top.sv
module pixout_stage_tb_top;
  localparam int TICKS = 48;
  localparam int LAT   = 11;
  localparam int STEP  = 5;

  logic       clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst;
  logic [5:0] tick;
  logic       stb;
  logic [9:0] sdata;
  logic [8:0] ctrl;
  logic [9:0] dout;
  logic       dclk;

  pixout_stage dut_i (
    .clk(clk), .rst(rst), .tick_pos(tick), .samp_stb(stb),
    .samp_data(sdata), .out_ctrl(ctrl), .dout(dout), .dclk(dclk)
  );

  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [9:0] wq [0:1023];
  int         p = 0;
  logic [8:0] sh = 9'h100;
  logic [9:0] cur_w = '0, exp_dout = '0;
  logic       exp_dclk;
  string      req_d = "R1";

  function automatic int eff_phase(logic [8:0] c);
    int ph = int'(c[5:0]);
    return (ph >= TICKS) ? ph - TICKS : ph;
  endfunction

  function automatic int upd_pos(logic [8:0] c);
    return (eff_phase(c) + int'(c[8:7]) * STEP) % TICKS;
  endfunction

  function automatic logic clk_model(logic [8:0] c, int t);
    if (c[6]) return (t >= TICKS / 2);
    return (((t - eff_phase(c) + TICKS) % TICKS) < TICKS / 2);
  endfunction

  task automatic chk(string r, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic step();
    int t = int'(tick);
    logic [8:0] sh_now = sh;
    exp_dclk = clk_model(sh_now, t);
    if (t == upd_pos(sh_now)) exp_dout = (p >= LAT) ? wq[p-LAT] : 10'd0;
    if (stb) cur_w = sdata;
    if (t == TICKS - 1) begin
      wq[p] = cur_w;
      sh = ctrl;
      p++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(req_d, int'(dout), int'(exp_dout));
    chk(sh_now[6] ? "R5" : "R4", int'(dclk), int'(exp_dclk));
  endtask

  // c0 drives the first half of the period, c1 the second; stb_t < 0 means no strobe
  task automatic run_period(logic [8:0] c0, logic [8:0] c1, int stb_t, logic [9:0] w, string r);
    req_d = r;
    for (int t = 0; t < TICKS; t++) begin
      tick  = 6'(t);
      ctrl  = (t < TICKS / 2) ? c0 : c1;
      stb   = (t == stb_t);
      sdata = (t == stb_t) ? w : 10'($urandom);
      step();
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    rst = 1'b1; tick = '0; stb = 1'b0; sdata = '0; ctrl = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(dout), 0);
    chk("R1", int'(dclk), 0);
    rst = 1'b0;

    // R1: period 0 runs on the reset default, not on the input word
    run_period(9'h0C5, 9'h0C5, 7, 10'h2A5, "R1");
    // R2: output stays zero until the line is full, then aligns to period k+11
    for (int k = 1; k < 14; k++)
      run_period(9'h100, 9'h100, int'($urandom % TICKS), 10'($urandom), "R2");

    // directed corners: each call sets the config checked in the next period
    run_period(9'h1AF, 9'h1AF, 3, 10'h3FF, "R3");   // next: delay code 3, phase 47
    run_period(9'h032, 9'h032, 9, 10'h001, "R6");   // checks wrap 47+15 -> 14
    run_period(9'h0DE, 9'h0DE, 20, 10'h155, "R7");  // checks phase code 50 -> 2
    run_period(9'h1FF, 9'h005, 30, 10'h0AA, "R5");  // checks fixed mode, phase 30
    run_period(9'h100, 9'h100, 47, 10'h3C3, "R8");  // checks 0x005 won over mid-period 0x1FF
    run_period(9'h100, 9'h100, -1, 10'h000, "R9");  // no strobe: repeats 0x3C3
    for (int k = 0; k < 12; k++)
      run_period(9'h100, 9'h100, (k == 0) ? 47 : int'($urandom % TICKS), 10'($urandom), "R9");

    // constrained random configuration and strobe placement
    for (int k = 0; k < 150; k++) begin
      logic [8:0] c = 9'($urandom);
      int st = (($urandom % 8) == 0) ? -1 : int'($urandom % TICKS);
      run_period(c, c, st, 10'($urandom), "R3");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule